// File: doc/BRIEF.md
# Lane-Selectable Link Event Counter

This block keeps one 32-bit count of a single chosen event taken from a grid of per-lane event strobes. The strobes cover data-link packets (acknowledge and flow-control update packets, nullified and duplicate transaction packets) and transaction-layer packet kinds for both directions. These kinds are memory, configuration and IO reads and writes, completions with and without data, messages, atomics, prefixed packets and alternate-protocol packets. Each clock cycle, the strobe input carries one bit for every (lane, event slot) pair.

Software selects the event and the lane, and starts or stops counting, through a control word at offset 0x8. It reads the count at offset 0xC. There is only one counter, so exactly one event on one lane is counted at any time. The counter stops at its all-ones value and does not wrap. A clear request in the control word zeroes the counter on the same edge as the write.

Top module: `lane_event_counter`

## Requirements
- R1: Control word layout at offset 0x8: event code in bits 27:16, lane number in bits 11:8, status in bit 7, enable field in bits 4:2 and clear field in bits 1:0. All other bits read 0. The count reads at offset 0xC, zero-extended to 32 bits. Reads of any other offset return 0. Writes to any offset other than 0x8 change nothing.
- R2: Writing enable field value 0x3 starts counting and writing 0x1 stops it. Any other enable value leaves the run state unchanged.
- R3: Status bit 7 reads 1 while counting runs and 0 otherwise. The enable field reads back 0x3 while running and 0x1 while stopped.
- R4: While running, each clock cycle in which the selected strobe is high adds exactly 1. Strobe bit index = lane*31 + slot. Codes 0x600..0x606 map to slots 0..6. Codes 0x700..0x717 map to slots 7..30 (slot = code - 0x700 + 7).
- R5: Writing clear value 1 zeroes the count at that write edge, and this takes precedence over an increment in the same cycle. Other clear values do nothing. The clear field always reads 0.
- R6: The count saturates at the all-ones value of the counter width (default 32 bits) and stays there until cleared.
- R7: Strobes of lanes other than the selected one are ignored, and a selected lane number at or beyond the lane count never counts.
- R8: Codes outside 0x600..0x606 and 0x700..0x717, and codes 0x70D and 0x70E, never count.
- R9: While stopped, the count holds its value.
- R10: After reset, the control word reads 0x00000004 (stopped, event 0, lane 0) and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | ADDR_W | Write byte offset |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | ADDR_W | Read byte offset |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| lane_evt | input | LANES*31 | Per-lane event strobes, bit lane*31+slot |

## Verification
Bursts on the selected strobe are mixed with bursts on the same slot of a neighbouring lane and on a different slot of the selected lane. This separates a correct lane-and-slot pick from an index off by one lane or one slot. Pulses on the slots that sit next to the unused codes and the invalid code 0x607 show whether the decoder rejects gaps in the code space. Stop, odd enable values and restart sequences separate the run state from the selection. A clear written in the same cycle as a strobe shows which one wins. A narrow second instance is driven past its all-ones value to show saturation rather than wrap, and it is pointed at a lane number beyond its lane count.

// File: rtl/lanecnt_pkg.sv
package lanecnt_pkg;
  localparam int NUM_SLOTS  = 31;
  localparam int SLOT_W     = 5;
  localparam int CODE_W     = 12;
  localparam int LANE_W     = 4;
  localparam int CTRL_OFS   = 8'h08;
  localparam int COUNT_OFS  = 8'h0C;
  localparam int CODE_LSB   = 16;
  localparam int LANE_LSB   = 8;
  localparam int STAT_BIT   = 7;
  localparam int ENA_LSB    = 2;
  localparam int CLR_LSB    = 0;
  localparam logic [2:0] ENA_OFF = 3'd1;
  localparam logic [2:0] ENA_ON  = 3'd3;
  localparam logic [1:0] CLR_GO  = 2'd1;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [LANE_W-1:0] lane;
  } pick_t;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  function automatic slot_t code_to_slot(logic [CODE_W-1:0] c);
    slot_t r;
    logic [CODE_W-1:0] d;
    r = '0;
    if (c >= 12'h600 && c <= 12'h606) begin
      d = c - 12'h600;
      r.ok = 1'b1;
      r.slot = d[SLOT_W-1:0];
    end else if (c >= 12'h700 && c <= 12'h717 && c != 12'h70D && c != 12'h70E) begin
      d = c - 12'h700 + 12'd7;
      r.ok = 1'b1;
      r.slot = d[SLOT_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/lc_ctrl_reg.sv
module lc_ctrl_reg
  import lanecnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic [31:0]        wdata,
  output pick_t              pick,
  output logic               run,
  output logic               clr
);
  pick_t pick_q, pick_d;
  logic  run_q, run_d;
  logic [2:0] ena_f;

  assign ena_f = wdata[ENA_LSB +: 3];

  always_comb begin
    pick_d = pick_q;
    run_d  = run_q;
    if (wr_ctrl) begin
      pick_d.code = wdata[CODE_LSB +: CODE_W];
      pick_d.lane = wdata[LANE_LSB +: LANE_W];
      if (ena_f == ENA_ON)       run_d = 1'b1;
      else if (ena_f == ENA_OFF) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_q <= '0;
      run_q  <= 1'b0;
    end else if (wr_ctrl) begin
      pick_q <= pick_d;
      run_q  <= run_d;
    end
  end

  assign pick = pick_q;
  assign run  = run_q;
  assign clr  = wr_ctrl && (wdata[CLR_LSB +: 2] == CLR_GO);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ena_f == ENA_ON) |=> run_q);
  assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ena_f == ENA_OFF) |=> !run_q);
  assert_keep_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl || (ena_f != ENA_ON && ena_f != ENA_OFF)) |=> $stable(run_q));
endmodule

// File: rtl/lc_event_pick.sv
module lc_event_pick
  import lanecnt_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  pick_t                      pick,
  input  logic [LANES*NUM_SLOTS-1:0] strobes,
  output logic                       hit
);
  slot_t sel;
  logic [LANES-1:0] lane_hit;

  assign sel = code_to_slot(pick.code);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [31:0] vec;
    assign vec = {{(32-NUM_SLOTS){1'b0}}, strobes[g*NUM_SLOTS +: NUM_SLOTS]};
    assign lane_hit[g] = sel.ok && vec[sel.slot];
  end

  always_comb begin
    hit = 1'b0;
    for (int g = 0; g < LANES; g++) begin
      if (pick.lane == LANE_W'(g)) hit = lane_hit[g];
    end
  end

  assert_far_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pick.lane) >= LANES) |-> !hit);
  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pick.code == 12'h70D || pick.code == 12'h70E || pick.code[11:8] == 4'h0) |-> !hit);
endmodule

// File: rtl/lc_sat_counter.sv
module lc_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ld;

  always_comb begin
    cnt_d = cnt_q;
    ld    = 1'b0;
    if (clr) begin
      cnt_d = '0;
      ld    = 1'b1;
    end else if (inc && cnt_q != TOP) begin
      cnt_d = cnt_q + 1'b1;
      ld    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr) |=> (cnt_q == TOP));
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/lane_event_counter.sv
module lane_event_counter
  import lanecnt_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_waddr,
  input  logic [31:0]                bus_wdata,
  input  logic [ADDR_W-1:0]          bus_raddr,
  output logic [31:0]                bus_rdata,
  input  logic [LANES*NUM_SLOTS-1:0] lane_evt
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(COUNT_OFS);

  logic             wr_ctrl, run, clr, hit;
  pick_t            pick;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl = bus_wr && (bus_waddr == A_CTRL);

  lc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .pick(pick), .run(run), .clr(clr)
  );

  lc_event_pick #(.LANES(LANES)) u_pick (
    .clk(clk), .rst_n(rst_n), .pick(pick), .strobes(lane_evt), .hit(hit)
  );

  lc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(run && hit), .cnt(cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_raddr == A_CTRL) begin
      bus_rdata[CODE_LSB +: CODE_W] = pick.code;
      bus_rdata[LANE_LSB +: LANE_W] = pick.lane;
      bus_rdata[STAT_BIT]           = run;
      bus_rdata[ENA_LSB +: 3]       = run ? ENA_ON : ENA_OFF;
    end else if (bus_raddr == A_COUNT) begin
      bus_rdata = 32'(cnt);
    end
  end

  assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == A_CTRL) |-> (bus_rdata[STAT_BIT] == (bus_rdata[ENA_LSB +: 3] == ENA_ON)));
  assert_clr_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == A_CTRL) |-> (bus_rdata[1:0] == 2'b00));
endmodule

// File: tb/lane_event_counter_test.sv
module lane_event_counter_test;
  localparam int NS = 31;
  localparam int LN = 16;
  localparam int LS = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        wr_a = 0, wr_b = 0;
  logic [7:0]  wa_a = 0, wa_b = 0, ra_a = 0, ra_b = 0;
  logic [31:0] wd_a = 0, wd_b = 0, rd_a, rd_b;
  logic [LN*NS-1:0] ev_a = '0;
  logic [LS*NS-1:0] ev_b = '0;

  int n_chk = 0, n_bad = 0;

  lane_event_counter #(.LANES(LN), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_waddr(wa_a), .bus_wdata(wd_a),
    .bus_raddr(ra_a), .bus_rdata(rd_a), .lane_evt(ev_a));

  lane_event_counter #(.LANES(LS), .CNT_W(4)) uut_small (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_waddr(wa_b), .bus_wdata(wd_b),
    .bus_raddr(ra_b), .bus_rdata(rd_b), .lane_evt(ev_b));

  function automatic logic [31:0] ctl(logic [11:0] code, logic [3:0] lane, logic [2:0] ena, logic [1:0] clr);
    return {4'h0, code, 4'h0, lane, 1'b0, 2'b00, ena, clr};
  endfunction

  task automatic wr(bit sm, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    if (sm) begin wr_b = 1; wa_b = a; wd_b = d; end
    else    begin wr_a = 1; wa_a = a; wd_a = d; end
    @(negedge clk);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic chk(bit sm, logic [7:0] a, logic [31:0] exp, string tag);
    if (sm) ra_b = a; else ra_a = a;
    #1;
    n_chk++;
    if ((sm ? rd_b : rd_a) !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %h got %h expected %h", tag, a, sm ? rd_b : rd_a, exp);
    end
  endtask

  task automatic pulse(bit sm, int idx, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sm) ev_b[idx] = 1'b1; else ev_a[idx] = 1'b1;
    end
    @(negedge clk);
    ev_a = '0; ev_b = '0;
  endtask

  task automatic t_reset;
    chk(0, 8'h08, 32'h0000_0004, "R10 ctrl after reset");
    chk(0, 8'h0C, 32'h0, "R10 count after reset");
  endtask

  task automatic t_basic;
    wr(0, 8'h08, ctl(12'h600, 4'd0, 3'd3, 2'd0));
    chk(0, 8'h08, 32'h0600_008C, "R1 R3 ctrl readback running");
    pulse(0, 0*NS + 0, 5);
    chk(0, 8'h0C, 32'd5, "R4 five tx-ack strobes");
  endtask

  task automatic t_lane;
    wr(0, 8'h08, ctl(12'h707, 4'd3, 3'd3, 2'd1));
    chk(0, 8'h0C, 32'd0, "R5 clear on select");
    pulse(0, 2*NS + 14, 3);
    pulse(0, 3*NS + 13, 2);
    pulse(0, 3*NS + 15, 2);
    chk(0, 8'h0C, 32'd0, "R7 neighbour lane and slots ignored");
    pulse(0, 3*NS + 14, 4);
    chk(0, 8'h0C, 32'd4, "R4 lane 3 completion with data");
  endtask

  task automatic t_codes;
    wr(0, 8'h08, ctl(12'h70D, 4'd1, 3'd3, 2'd1));
    for (int s = 0; s < NS; s++) pulse(0, 1*NS + s, 1);
    chk(0, 8'h0C, 32'd0, "R8 unused code 0x70D");
    wr(0, 8'h08, ctl(12'h607, 4'd1, 3'd3, 2'd0));
    for (int s = 0; s < NS; s++) pulse(0, 1*NS + s, 1);
    chk(0, 8'h0C, 32'd0, "R8 invalid code 0x607");
    wr(0, 8'h08, ctl(12'h717, 4'd1, 3'd3, 2'd0));
    pulse(0, 1*NS + 30, 2);
    chk(0, 8'h0C, 32'd2, "R4 last slot 0x717");
  endtask

  task automatic t_enable;
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd3, 2'd1));
    pulse(0, 2*NS + 25, 2);
    chk(0, 8'h0C, 32'd2, "R4 rx completion with data");
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd1, 2'd0));
    chk(0, 8'h08, 32'h0712_0204, "R3 ctrl readback stopped");
    pulse(0, 2*NS + 25, 3);
    chk(0, 8'h0C, 32'd2, "R9 stopped count holds");
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd5, 2'd0));
    pulse(0, 2*NS + 25, 2);
    chk(0, 8'h0C, 32'd2, "R2 odd enable value keeps stop");
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd3, 2'd0));
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd0, 2'd0));
    pulse(0, 2*NS + 25, 1);
    chk(0, 8'h0C, 32'd3, "R2 restart then enable 0 keeps run");
  endtask

  task automatic t_clear;
    wr(0, 8'h08, ctl(12'h712, 4'd2, 3'd3, 2'd2));
    chk(0, 8'h0C, 32'd3, "R5 clear value 2 no effect");
    @(negedge clk);
    wr_a = 1; wa_a = 8'h08; wd_a = ctl(12'h712, 4'd2, 3'd3, 2'd1); ev_a[2*NS + 25] = 1'b1;
    @(negedge clk);
    wr_a = 0; ev_a = '0;
    chk(0, 8'h0C, 32'd0, "R5 clear beats increment");
    chk(0, 8'h08, 32'h0712_028C, "R5 clear field reads zero");
  endtask

  task automatic t_offsets;
    pulse(0, 2*NS + 25, 6);
    wr(0, 8'h0C, 32'h0);
    wr(0, 8'h10, 32'hFFFF_FFFF);
    chk(0, 8'h0C, 32'd6, "R1 writes elsewhere ignored");
    chk(0, 8'h10, 32'd0, "R1 unmapped offset reads zero");
    chk(0, 8'h08, 32'h0712_028C, "R1 ctrl unchanged by other writes");
  endtask

  task automatic t_saturate;
    wr(1, 8'h08, ctl(12'h600, 4'd1, 3'd3, 2'd1));
    pulse(1, 1*NS + 0, 20);
    chk(1, 8'h0C, 32'd15, "R6 narrow counter saturates");
    wr(1, 8'h08, ctl(12'h600, 4'd5, 3'd3, 2'd1));
    ev_b = '1;
    repeat (4) @(negedge clk);
    ev_b = '0;
    chk(1, 8'h0C, 32'd0, "R7 lane beyond lane count");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_lane;
    t_codes;
    t_enable;
    t_clear;
    t_offsets;
    t_saturate;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule